// File: doc/BRIEF.md
# Fragment-aware translation lookaside buffer

This block is a small fully associative translation cache. Each cached entry can describe a run of physical pages longer than 4KB. A 3-bit fragment code inside the entry sets the span. A code of f makes one entry cover 2^f consecutive 4KB virtual pages, so the entry maps a region of 1 << (12 + f) bytes. Any virtual page number inside that naturally aligned region hits the entry. The returned physical page number is the entry's aligned physical base with the low f bits of the virtual page number placed into it. The flags of the entry apply to every page of the region.

Lookups travel on a valid/ready request channel. The answer is registered and leaves on a valid/ready result channel one cycle after the request is accepted. A request is accepted only when the result register is empty or is being drained in the same cycle. While `rs_valid` is high and `rs_ready` is low, the result holds steady and `lk_ready` stays low.

A separate valid/ready fill channel writes entries fetched after a miss. Slots are chosen in round-robin order. A level input, `inval_all`, drops every entry. A second level input, `frag_en`, controls fragment handling. When `frag_en` is low, every entry is treated as a single 4KB page.

Top module: `frag_tlb`

## Requirements
- R1: After reset, `rs_valid` is low, `lk_ready` is high and every entry is empty, so the first lookups miss.
- R2: An accepted lookup (`lk_valid` and `lk_ready`) produces `rs_valid` on the next cycle. `lk_ready` equals `!rs_valid || rs_ready`. A result that is not taken holds all of its fields until `rs_ready` is high. A miss returns zero physical page, zero flags and zero fragment.
- R3: The fill entry layout is as follows. Bits 6:0 are the flags, and bit 0 is the valid bit. Bits 9:7 are the fragment code. Bits above 9 are the physical page number. An entry filled with bit 0 clear never hits. A hit always reports flag bit 0 set.
- R4: An entry filled with virtual page V and fragment f hits every lookup page P for which P and V agree above bit f−1. The stored tag and base are aligned down to 2^f pages.
- R5: On a hit, the physical page is the entry's base with its low f bits cleared, ORed with the low f bits of P. The flags are the entry's flags for every page of the region.
- R6: While `frag_en` is low, an entry matches only its aligned base page. It returns the aligned physical base, and it reports a fragment of 0.
- R7: While `inval_all` is high, `fl_ready` is low. A lookup accepted in that cycle misses. After that cycle every entry is empty.
- R8: Fills go to slots 0, 1, …, NE−1 and then wrap, so fill number NE+1 replaces the entry written by the first fill.
- R9: When several entries match, the lowest-numbered slot supplies the result.
- R10: A fill is visible to lookups accepted from the cycle after it. A lookup accepted in the same cycle as the fill sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_en | input | 1 | Fragment handling enable; when low, every entry is a 4KB page |
| inval_all | input | 1 | Drop all entries this cycle |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result taken by the consumer |
| rs_hit | output | 1 | Translation found |
| rs_ppn | output | PPN_W | Translated physical page number |
| rs_flags | output | 7 | Entry flags, with bit 0 as valid |
| rs_frag | output | 3 | Effective fragment code of the hitting entry |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill accepted (low during invalidate) |
| fl_vpn | input | VPN_W | Virtual page number of the fetched entry |
| fl_pte | input | PPN_W+10 | Entry: flags [6:0], fragment [9:7], physical page above |

## Verification
The checker assumes that the consumer obeys the result handshake. It also assumes that `frag_en` changes only between accepted lookups; changing it at other times still yields a legal result. The checker does not assume that fills avoid overlapping ranges. Overlap is allowed, and priority settles it.

The stimulus keeps `rst_n` low for several cycles before any traffic. It drives every input on the falling edge. It mixes random back-pressure, random fragment codes and rare invalidate pulses. Lookup pages are kept in a narrow window, so that hits, overlaps and slot reuse occur often.

// File: rtl/frag_tlb_pkg.sv
package frag_tlb_pkg;
  localparam int FLAG_W   = 7;
  localparam int FRAG_W   = 3;
  localparam int FRAG_LSB = 7;
  localparam int CTRL_W   = FLAG_W + FRAG_W;

  // Low-bit mask covering 2^f pages.
  function automatic logic [31:0] span_mask(input logic [FRAG_W-1:0] f);
    return (32'd1 << f) - 32'd1;
  endfunction
endpackage

// File: rtl/frag_tlb_entry.sv
module frag_tlb_entry
  import frag_tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  localparam int PTE_W = CTRL_W + PPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr,
  input  logic              frag_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PTE_W-1:0]  wr_pte,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn,
  output logic [FLAG_W-1:0] flags,
  output logic [FRAG_W-1:0] frag
);
  logic              vld;
  logic [VPN_W-1:0]  tag;
  logic [PPN_W-1:0]  base;
  logic [FLAG_W-1:0] flg;
  logic [FRAG_W-1:0] frg;

  logic [FRAG_W-1:0] wr_frag;
  logic [VPN_W-1:0]  wr_vmask;
  logic [PPN_W-1:0]  wr_pmask;
  logic [FRAG_W-1:0] eff_frag;
  logic [VPN_W-1:0]  lk_mask;

  assign wr_frag  = wr_pte[FRAG_LSB +: FRAG_W];
  assign wr_vmask = VPN_W'(span_mask(wr_frag));
  assign wr_pmask = PPN_W'(span_mask(wr_frag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      tag  <= '0;
      base <= '0;
      flg  <= '0;
      frg  <= '0;
    end else if (clr) begin
      vld <= 1'b0;
    end else if (wr_en) begin
      vld  <= wr_pte[0];
      tag  <= wr_vpn & ~wr_vmask;
      base <= wr_pte[PTE_W-1:CTRL_W] & ~wr_pmask;
      flg  <= wr_pte[FLAG_W-1:0];
      frg  <= wr_frag;
    end
  end

  assign eff_frag = frag_en ? frg : '0;
  assign lk_mask  = VPN_W'(span_mask(eff_frag));
  assign hit      = vld && ((lk_vpn & ~lk_mask) == tag);
  assign ppn      = base | PPN_W'(lk_vpn & lk_mask);
  assign flags    = flg;
  assign frag     = eff_frag;
endmodule

// File: rtl/frag_tlb_pick.sv
module frag_tlb_pick
  import frag_tlb_pkg::*;
#(
  parameter int NE    = 8,
  parameter int PPN_W = 24
) (
  input  logic [NE-1:0]             hit_vec,
  input  logic [NE-1:0][PPN_W-1:0]  ppn_vec,
  input  logic [NE-1:0][FLAG_W-1:0] flag_vec,
  input  logic [NE-1:0][FRAG_W-1:0] frag_vec,
  output logic                      any,
  output logic [PPN_W-1:0]          ppn,
  output logic [FLAG_W-1:0]         flags,
  output logic [FRAG_W-1:0]         frag
);
  // Lowest index wins: scan downward so the last assignment is slot 0.
  always_comb begin
    ppn   = '0;
    flags = '0;
    frag  = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        ppn   = ppn_vec[i];
        flags = flag_vec[i];
        frag  = frag_vec[i];
      end
    end
  end

  assign any = |hit_vec;
endmodule

// File: rtl/frag_tlb.sv
module frag_tlb
  import frag_tlb_pkg::*;
#(
  parameter int NE    = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  localparam int PTE_W = CTRL_W + PPN_W,
  localparam int PTR_W = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frag_en,
  input  logic              inval_all,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic [FLAG_W-1:0] rs_flags,
  output logic [FRAG_W-1:0] rs_frag,
  input  logic              fl_valid,
  output logic              fl_ready,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PTE_W-1:0]  fl_pte
);
  logic                      lk_fire;
  logic                      fl_fire;
  logic [PTR_W-1:0]          fill_ptr;
  logic [NE-1:0]             hit_vec;
  logic [NE-1:0][PPN_W-1:0]  ppn_vec;
  logic [NE-1:0][FLAG_W-1:0] flag_vec;
  logic [NE-1:0][FRAG_W-1:0] frag_vec;
  logic                      sel_any;
  logic [PPN_W-1:0]          sel_ppn;
  logic [FLAG_W-1:0]         sel_flags;
  logic [FRAG_W-1:0]         sel_frag;

  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign fl_ready = !inval_all;
  assign fl_fire  = fl_valid && fl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_ptr <= '0;
    end else if (fl_fire) begin
      fill_ptr <= (fill_ptr == PTR_W'(NE - 1)) ? '0 : fill_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_slot
    frag_tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fl_fire && (fill_ptr == PTR_W'(g))),
      .clr     (inval_all),
      .frag_en (frag_en),
      .wr_vpn  (fl_vpn),
      .wr_pte  (fl_pte),
      .lk_vpn  (lk_vpn),
      .hit     (hit_vec[g]),
      .ppn     (ppn_vec[g]),
      .flags   (flag_vec[g]),
      .frag    (frag_vec[g])
    );
  end

  frag_tlb_pick #(.NE(NE), .PPN_W(PPN_W)) u_pick (
    .hit_vec  (hit_vec),
    .ppn_vec  (ppn_vec),
    .flag_vec (flag_vec),
    .frag_vec (frag_vec),
    .any      (sel_any),
    .ppn      (sel_ppn),
    .flags    (sel_flags),
    .frag     (sel_frag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_ppn   <= '0;
      rs_flags <= '0;
      rs_frag  <= '0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= sel_any && !inval_all;
      rs_ppn   <= (sel_any && !inval_all) ? sel_ppn   : '0;
      rs_flags <= (sel_any && !inval_all) ? sel_flags : '0;
      rs_frag  <= (sel_any && !inval_all) ? sel_frag  : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/frag_tlb_chk.sv
module frag_tlb_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frag_en,
  input logic             inval_all,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic             rs_hit,
  input logic [PPN_W-1:0] rs_ppn,
  input logic [6:0]       rs_flags,
  input logic [2:0]       rs_frag,
  input logic             fl_ready
);
  a_r2_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_hit) && $stable(rs_ppn)
                              && $stable(rs_flags) && $stable(rs_frag));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_ppn == '0 && rs_flags == '0 && rs_frag == '0);

  a_r3_hit_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_hit |-> rs_flags[0]);

  a_r6_frag_off: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !frag_en |=> rs_frag == 3'd0);

  a_r7_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |-> !fl_ready);

  a_r7_inval_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && inval_all |=> !rs_hit);
endmodule

bind frag_tlb frag_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frag_en   (frag_en),
  .inval_all (inval_all),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .rs_valid  (rs_valid),
  .rs_ready  (rs_ready),
  .rs_hit    (rs_hit),
  .rs_ppn    (rs_ppn),
  .rs_flags  (rs_flags),
  .rs_frag   (rs_frag),
  .fl_ready  (fl_ready)
);

// File: tb/test_frag_tlb.sv
module test_frag_tlb;
  localparam int NE    = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 24;
  localparam int PTE_W = PPN_W + 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             frag_en = 1'b1;
  logic             inval_all = 1'b0;
  logic             lk_valid = 1'b0;
  logic             lk_ready;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic             rs_valid;
  logic             rs_ready = 1'b1;
  logic             rs_hit;
  logic [PPN_W-1:0] rs_ppn;
  logic [6:0]       rs_flags;
  logic [2:0]       rs_frag;
  logic             fl_valid = 1'b0;
  logic             fl_ready;
  logic [VPN_W-1:0] fl_vpn = '0;
  logic [PTE_W-1:0] fl_pte = '0;

  frag_tlb #(.NE(NE), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_frag_tlb (
    .clk(clk), .rst_n(rst_n), .frag_en(frag_en), .inval_all(inval_all),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_ppn(rs_ppn), .rs_flags(rs_flags), .rs_frag(rs_frag),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_vpn(fl_vpn), .fl_pte(fl_pte)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Behavioural reference: a list of regions searched in order.
  bit     m_v   [NE];
  longint m_tag [NE];
  longint m_base[NE];
  int     m_flg [NE];
  int     m_frg [NE];
  int     m_ptr;
  bit     e_valid, e_hit;
  longint e_ppn;
  int     e_flg, e_frg;
  bit     t_acc;
  int     t_win, t_eff, t_f;
  longint t_msk, t_wmsk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        m_v[i] = 0; m_tag[i] = 0; m_base[i] = 0; m_flg[i] = 0; m_frg[i] = 0;
      end
      m_ptr = 0; e_valid = 0; e_hit = 0; e_ppn = 0; e_flg = 0; e_frg = 0;
    end else begin
      t_acc = lk_valid && (!e_valid || rs_ready);
      if (t_acc) begin
        t_win = -1; t_wmsk = 0;
        for (int i = 0; i < NE; i++) begin
          t_eff = frag_en ? m_frg[i] : 0;
          t_msk = (64'd1 << t_eff) - 1;
          if (t_win < 0 && m_v[i] && !inval_all &&
              ((longint'(lk_vpn) & ~t_msk) == m_tag[i])) begin
            t_win = i; t_wmsk = t_msk;
          end
        end
        e_valid = 1;
        if (t_win >= 0) begin
          e_hit = 1;
          e_ppn = m_base[t_win] | (longint'(lk_vpn) & t_wmsk);
          e_flg = m_flg[t_win];
          e_frg = frag_en ? m_frg[t_win] : 0;
        end else begin
          e_hit = 0; e_ppn = 0; e_flg = 0; e_frg = 0;
        end
      end else if (rs_ready) begin
        e_valid = 0;
      end
      if (fl_valid && !inval_all) begin
        t_f = int'(fl_pte[9:7]);
        t_msk = (64'd1 << t_f) - 1;
        m_v[m_ptr]    = fl_pte[0];
        m_tag[m_ptr]  = longint'(fl_vpn) & ~t_msk;
        m_base[m_ptr] = longint'(fl_pte[PTE_W-1:10]) & ~t_msk;
        m_flg[m_ptr]  = int'(fl_pte[6:0]);
        m_frg[m_ptr]  = t_f;
        m_ptr = (m_ptr + 1) % NE;
      end
      if (inval_all)
        for (int i = 0; i < NE; i++) m_v[i] = 0;
    end
  end

  task automatic mis(input string req, input string what, input longint got, input longint exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
  endtask

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      n_vec++;
      if (rs_valid !== e_valid) mis("R2", "rs_valid", longint'(rs_valid), longint'(e_valid));
      if (lk_ready !== (!e_valid || rs_ready))
        mis("R2", "lk_ready", longint'(lk_ready), longint'(!e_valid || rs_ready));
      if (fl_ready !== !inval_all) mis("R7", "fl_ready", longint'(fl_ready), longint'(!inval_all));
      if (e_valid) begin
        if (rs_hit !== e_hit) mis("R4", "rs_hit", longint'(rs_hit), longint'(e_hit));
        if (longint'(rs_ppn) != e_ppn) mis("R5", "rs_ppn", longint'(rs_ppn), e_ppn);
        if (int'(rs_flags) != e_flg) mis("R5", "rs_flags", longint'(rs_flags), longint'(e_flg));
        if (int'(rs_frag) != e_frg) mis("R6", "rs_frag", longint'(rs_frag), longint'(e_frg));
      end
    end
  end

  task automatic chk(input string req, input longint got, input longint exp);
    n_vec++;
    if (got != exp) mis(req, "directed", got, exp);
  endtask

  function automatic logic [PTE_W-1:0] mk(input logic [PPN_W-1:0] p, input logic [2:0] f,
                                          input logic [6:0] fl);
    return {p, f, fl};
  endfunction

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PTE_W-1:0] e);
    @(negedge clk); fl_valid = 1'b1; fl_vpn = v; fl_pte = e;
    @(negedge clk); fl_valid = 1'b0;
  endtask

  bit     g_hit;
  longint g_ppn;
  int     g_flg, g_frg;

  task automatic look(input logic [VPN_W-1:0] v);
    @(negedge clk); lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk); lk_valid = 1'b0;
    #2;
    g_hit = rs_hit; g_ppn = longint'(rs_ppn); g_flg = int'(rs_flags); g_frg = int'(rs_frag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mis("R2", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 rs_valid after reset", longint'(rs_valid), 0);
    chk("R1 lk_ready after reset", longint'(lk_ready), 1);
    look(20'h00010);
    chk("R1 empty miss", longint'(g_hit), 0);

    // R10: fill and lookup in the same cycle; lookup sees old contents.
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = 20'h00123; fl_pte = mk(24'h00ABC5, 3'd4, 7'h61);
    lk_valid = 1'b1; lk_vpn = 20'h00123;
    @(negedge clk); fl_valid = 1'b0; lk_valid = 1'b0; #2;
    chk("R10 same-cycle miss", longint'(rs_hit), 0);
    look(20'h00123);
    chk("R10 next-cycle hit", longint'(g_hit), 1);
    chk("R5 ppn inside fragment", g_ppn, 64'h0ABC3);

    // R4/R5: whole 16-page region covered.
    look(20'h0012F);
    chk("R4 top page hit", longint'(g_hit), 1);
    chk("R5 ppn top page", g_ppn, 64'h0ABCF);
    chk("R5 flags shared", longint'(g_flg), 64'h61);
    chk("R4 frag reported", longint'(g_frg), 4);
    look(20'h00130);
    chk("R4 outside region miss", longint'(g_hit), 0);

    // R6: fragment handling off.
    frag_en = 1'b0;
    look(20'h00125);
    chk("R6 non-base page miss", longint'(g_hit), 0);
    look(20'h00120);
    chk("R6 base page hit", longint'(g_hit), 1);
    chk("R6 base ppn", g_ppn, 64'h0ABC0);
    chk("R6 frag zero", longint'(g_frg), 0);
    frag_en = 1'b1;

    // R3: entry with valid bit clear (slot 1).
    fill(20'h00400, mk(24'h000333, 3'd0, 7'h60));
    look(20'h00400);
    chk("R3 invalid entry never hits", longint'(g_hit), 0);

    // R9: overlap, slot 0 (frag 4) wins over slot 2 (4KB).
    fill(20'h00124, mk(24'h000777, 3'd0, 7'h01));
    look(20'h00124);
    chk("R9 lowest slot wins", g_ppn, 64'h0ABC4);

    // 256KB fragment in slot 3.
    fill(20'h00255, mk(24'h012345, 3'd6, 7'h03));
    look(20'h0027F);
    chk("R5 frag6 ppn", g_ppn, 64'h01237F);
    look(20'h00280);
    chk("R4 frag6 outside miss", longint'(g_hit), 0);

    // R8: slots 4..7, then wrap to slot 0.
    for (int i = 0; i < 4; i++) fill(20'h00800 + VPN_W'(i), mk(24'h000100 + PPN_W'(i), 3'd0, 7'h01));
    fill(20'h00900, mk(24'h000005, 3'd0, 7'h01));
    look(20'h00123);
    chk("R8 slot0 replaced", longint'(g_hit), 0);
    look(20'h00124);
    chk("R8 slot2 now serves", g_ppn, 64'h000777);
    look(20'h00900);
    chk("R8 wrapped fill hit", g_ppn, 64'h000005);
    look(20'h00803);
    chk("R8 slot7 kept", g_ppn, 64'h000103);

    // R2: back-pressure holds result and blocks the next request.
    @(negedge clk); rs_ready = 1'b0; lk_valid = 1'b1; lk_vpn = 20'h00124;
    @(negedge clk); lk_vpn = 20'h00900; #2;
    chk("R2 result present", longint'(rs_valid), 1);
    chk("R2 lk_ready low when stalled", longint'(lk_ready), 0);
    @(negedge clk); #2;
    chk("R2 held ppn", longint'(rs_ppn), 64'h000777);
    rs_ready = 1'b1;
    @(negedge clk); lk_valid = 1'b0; #2;
    chk("R2 next result after drain", longint'(rs_ppn), 64'h000005);

    // R7: invalidate with a same-cycle lookup and fill.
    @(negedge clk);
    inval_all = 1'b1; lk_valid = 1'b1; lk_vpn = 20'h00900;
    fl_valid = 1'b1; fl_vpn = 20'h00A00; fl_pte = mk(24'h000009, 3'd0, 7'h01);
    #2;
    chk("R7 fl_ready low", longint'(fl_ready), 0);
    @(negedge clk); inval_all = 1'b0; lk_valid = 1'b0; fl_valid = 1'b0; #2;
    chk("R7 same-cycle lookup misses", longint'(rs_hit), 0);
    look(20'h00255);
    chk("R7 all entries dropped", longint'(g_hit), 0);
    look(20'h00A00);
    chk("R7 fill blocked", longint'(g_hit), 0);

    // Random traffic checked by the reference every clock.
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lk_valid  = ($urandom % 3) != 0;
      lk_vpn    = VPN_W'($urandom % 1024);
      rs_ready  = ($urandom % 4) != 0;
      fl_valid  = ($urandom % 5) == 0;
      fl_vpn    = VPN_W'($urandom % 1024);
      fl_pte    = mk(PPN_W'($urandom), 3'($urandom % 8), {6'($urandom), 1'(($urandom % 8) != 0)});
      inval_all = ($urandom % 97) == 0;
      if (($urandom % 50) == 0) frag_en = ~frag_en;
    end
    @(negedge clk);
    lk_valid = 1'b0; fl_valid = 1'b0; inval_all = 1'b0; rs_ready = 1'b1;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule